// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a virtual address to a physical address by following translation tables that sit in ordinary physical memory. A walk begins at a context table, located from a table-pointer register and a 4-bit context number. It then passes through a region table (256 entries), a segment table (64 entries) and a page table (64 entries). Each step is one 32-bit word read on a simple request/acknowledge memory port.

The two low bits of every entry give its kind. The three upper levels must hold descriptors that point to the next table, and the last level must hold a leaf entry. The leaf carries a 24-bit physical page number, a cacheable flag, modified and referenced flags, and a 3-bit permission code. The walker checks that code against the privilege mode and the access direction. If the access is allowed and the referenced or modified flag has to change, it writes the updated leaf back to the same address. It then reports either a 36-bit physical address or a fault, together with the level that was reached and the reason for the fault.

A walk starts with a one-cycle `start` pulse while the block is idle. Its result is valid while `done` is high for one cycle, and it stays on the outputs until the next walk begins.

Top module: `ptw_walker`

## Requirements
- R1: The first read goes to address `((ctp with bits 1:0 cleared) << 4) | (ctx << 2)`, truncated to 32 bits.
- R2: For each following level, the address is `((descriptor with bits 1:0 cleared) << 4) | (index << 2)`. The index is va[31:24] at the region level, va[23:18] at the segment level and va[17:12] at the page level.
- R3: At levels 0 to 2 (context, region, segment) an entry must have type 1 (descriptor). Type 0 gives fault cause 1 (invalid), and types 2 or 3 give fault cause 2 (wrong type). `fault_level` is set to the level at which the entry was read.
- R4: At level 3 an entry must have type 2 (leaf). Type 0 gives cause 1, and types 1 or 3 give cause 2, both with `fault_level` = 3.
- R5: A user-mode access to a leaf whose permission code (bits 4:2) is 6 or 7 gives cause 3 (protection) at level 3. User-mode reads of codes 0 to 5 and all supervisor reads are allowed.
- R6: A write is allowed only when the mode grants it. In user mode that means code 1 or 3. In supervisor mode it means code 1, 3, 5 or 7. Any other write gives cause 3 at level 3.
- R7: On success `fault` is 0, `pa` equals {leaf[31:8], va[11:0]} and `cacheable` equals leaf bit 7.
- R8: After an allowed access, the leaf is written back to the same address with bit 5 (referenced) set, and also bit 6 (modified) set when the access is a write. The write takes place only if this changes the entry. No write occurs on any fault.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. `done` lasts exactly one cycle. A `start` pulse that arrives during a walk is ignored and not queued.
- R10: During and after reset the block is idle, with `busy`, `done` and `mem_req` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a walk when idle |
| va | input | 32 | Virtual address |
| ctx | input | 4 | Context number |
| ctp | input | 32 | Context-table pointer register |
| is_write | input | 1 | Access is a write |
| is_user | input | 1 | Access is in user mode |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Walk ended in a fault |
| fault_level | output | 2 | Level reached (0 context .. 3 page) |
| fault_cause | output | 2 | 0 none, 1 invalid, 2 wrong type, 3 protection |
| pa | output | 36 | Physical address |
| cacheable | output | 1 | Leaf cacheable flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address (byte-addressed) |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume that memory answers a request with a single-cycle `mem_ack`, that it raises the acknowledge only while `mem_req` is high, and that it never acknowledges two cycles in a row. The bench memory model is built this way: it registers one acknowledge for each request it has not yet answered, so the walker always sees a request cycle followed by an acknowledge cycle. The assertions also expect `start` to be a pulse. The bench raises it for exactly one cycle, away from the clock edge.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int WORD_W   = 32;
  localparam int CTX_W    = 4;
  localparam int OFF_W    = 12;
  localparam int PPN_W    = 24;
  localparam int PA_W     = PPN_W + OFF_W;
  localparam int IDX_W    = 8;
  localparam int LAST_LVL = 3;
  localparam int REF_BIT  = 5;
  localparam int MOD_BIT  = 6;
  localparam int CACHE_BIT = 7;
  localparam int PERM_LO  = 2;
  localparam int PERM_W   = 3;
  localparam int TBL_SHIFT = 4;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_DESC    = 2'd1,
    ET_LEAF    = 2'd2,
    ET_RSVD    = 2'd3
  } etype_t;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_INVALID = 2'd1,
    FC_TYPE    = 2'd2,
    FC_PROT    = 2'd3
  } fcause_t;

  function automatic logic [WORD_W-1:0] ctx_entry_addr(
      input logic [WORD_W-1:0] ptr, input logic [CTX_W-1:0] c);
    logic [WORD_W-1:0] base;
    base = {ptr[WORD_W-1:2], 2'b00} << TBL_SHIFT;
    return base | (WORD_W'(c) << 2);
  endfunction

  function automatic logic [WORD_W-1:0] table_entry_addr(
      input logic [WORD_W-1:0] desc, input logic [IDX_W-1:0] idx);
    logic [WORD_W-1:0] base;
    base = {desc[WORD_W-1:2], 2'b00} << TBL_SHIFT;
    return base | (WORD_W'(idx) << 2);
  endfunction

  function automatic logic [IDX_W-1:0] va_index(
      input logic [WORD_W-1:0] v, input logic [1:0] lvl);
    case (lvl)
      2'd1:    return v[31:24];
      2'd2:    return {2'b00, v[23:18]};
      2'd3:    return {2'b00, v[17:12]};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
(
  input  logic [1:0]        lvl,
  input  logic [WORD_W-1:0] entry,
  output fcause_t           cause
);
  etype_t kind;
  etype_t want;

  assign kind = etype_t'(entry[1:0]);
  assign want = (lvl == 2'(LAST_LVL)) ? ET_LEAF : ET_DESC;

  always_comb begin
    if (kind == ET_INVALID)   cause = FC_INVALID;
    else if (kind != want)    cause = FC_TYPE;
    else                      cause = FC_NONE;
  end
endmodule

// File: rtl/ptw_perm_chk.sv
module ptw_perm_chk
  import ptw_pkg::*;
(
  input  logic [PERM_W-1:0] code,
  input  logic              user,
  input  logic              wr,
  output logic              grant
);
  logic user_reach;
  logic wr_ok;

  // codes above 5 are supervisor-only
  assign user_reach = !(user && (code > 3'd5));

  always_comb begin
    if (user) wr_ok = (code == 3'd1) || (code == 3'd3);
    else      wr_ok = code[0];
  end

  assign grant = user_reach && (!wr || wr_ok);
endmodule

// File: rtl/ptw_leaf_upd.sv
module ptw_leaf_upd
  import ptw_pkg::*;
(
  input  logic [WORD_W-1:0] leaf_in,
  input  logic              wr,
  output logic [WORD_W-1:0] leaf_out,
  output logic              need_wb
);
  logic [WORD_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[REF_BIT] = 1'b1;
    set_mask[MOD_BIT] = wr;
  end

  assign leaf_out = leaf_in | set_mask;
  assign need_wb  = (leaf_out != leaf_in);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] va,
  input  logic [CTX_W-1:0]  ctx,
  input  logic [WORD_W-1:0] ctp,
  input  logic              is_write,
  input  logic              is_user,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [1:0]        fault_level,
  output logic [1:0]        fault_cause,
  output logic [PA_W-1:0]   pa,
  output logic              cacheable,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WB, S_DONE} st_t;

  st_t               state;
  logic [1:0]        lvl;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] va_q;
  logic              user_q;
  logic              wr_q;
  logic [WORD_W-1:0] leaf_q;
  logic              fault_q;
  logic [1:0]        flvl_q;
  fcause_t           fcause_q;
  logic [PA_W-1:0]   pa_q;
  logic              cache_q;

  fcause_t           ent_cause;
  logic              grant;
  logic [WORD_W-1:0] upd_leaf;
  logic              need_wb;

  ptw_entry_chk u_ent (
    .lvl   (lvl),
    .entry (mem_rdata),
    .cause (ent_cause)
  );

  ptw_perm_chk u_perm (
    .code  (mem_rdata[PERM_LO +: PERM_W]),
    .user  (user_q),
    .wr    (wr_q),
    .grant (grant)
  );

  ptw_leaf_upd u_leaf (
    .leaf_in  (mem_rdata),
    .wr       (wr_q),
    .leaf_out (upd_leaf),
    .need_wb  (need_wb)
  );

  // named events of the walk
  logic walk_launch, entry_back, step_down, entry_fault, prot_fault, leaf_accept;
  assign walk_launch = (state == S_IDLE) && start;
  assign entry_back  = (state == S_READ) && mem_ack;
  assign entry_fault = entry_back && (ent_cause != FC_NONE);
  assign step_down   = entry_back && !entry_fault && (lvl != 2'(LAST_LVL));
  assign prot_fault  = entry_back && !entry_fault && (lvl == 2'(LAST_LVL)) && !grant;
  assign leaf_accept = entry_back && !entry_fault && (lvl == 2'(LAST_LVL)) && grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lvl      <= '0;
      addr_q   <= '0;
      va_q     <= '0;
      user_q   <= 1'b0;
      wr_q     <= 1'b0;
      leaf_q   <= '0;
      fault_q  <= 1'b0;
      flvl_q   <= '0;
      fcause_q <= FC_NONE;
      pa_q     <= '0;
      cache_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (walk_launch) begin
            va_q     <= va;
            user_q   <= is_user;
            wr_q     <= is_write;
            lvl      <= '0;
            addr_q   <= ctx_entry_addr(ctp, ctx);
            fault_q  <= 1'b0;
            flvl_q   <= '0;
            fcause_q <= FC_NONE;
            state    <= S_READ;
          end
        end
        S_READ: begin
          if (entry_fault) begin
            fault_q  <= 1'b1;
            fcause_q <= ent_cause;
            flvl_q   <= lvl;
            state    <= S_DONE;
          end else if (step_down) begin
            lvl    <= lvl + 2'd1;
            addr_q <= table_entry_addr(mem_rdata, va_index(va_q, lvl + 2'd1));
          end else if (prot_fault) begin
            fault_q  <= 1'b1;
            fcause_q <= FC_PROT;
            flvl_q   <= lvl;
            state    <= S_DONE;
          end else if (leaf_accept) begin
            pa_q    <= {mem_rdata[WORD_W-1 -: PPN_W], va_q[OFF_W-1:0]};
            cache_q <= mem_rdata[CACHE_BIT];
            leaf_q  <= upd_leaf;
            state   <= need_wb ? S_WB : S_DONE;
          end
        end
        S_WB: begin
          if (mem_ack) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_DONE);
  assign fault       = fault_q;
  assign fault_level = flvl_q;
  assign fault_cause = fcause_q;
  assign pa          = pa_q;
  assign cacheable   = cache_q;
  assign mem_req     = (state == S_READ) || (state == S_WB);
  assign mem_we      = (state == S_WB);
  assign mem_addr    = addr_q;
  assign mem_wdata   = (state == S_WB) ? leaf_q : '0;

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_wb_marks_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[REF_BIT] && mem_wdata[1:0] == 2'(ET_LEAF)));

  a_r3_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_cause != 2'(FC_NONE)));

  a_r5_prot_at_leaf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault && fault_cause == 2'(FC_PROT)) |-> (fault_level == 2'(LAST_LVL)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !done));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int WALK_LIMIT = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va = '0;
  logic [3:0]  ctx = '0;
  logic [31:0] ctp = '0;
  logic        is_write = 1'b0;
  logic        is_user = 1'b0;
  logic        busy, done, fault, cacheable;
  logic [1:0]  fault_level, fault_cause;
  logic [35:0] pa;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  logic [31:0] mem [logic [31:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .ctx(ctx), .ctp(ctp),
    .is_write(is_write), .is_user(is_user), .busy(busy), .done(done),
    .fault(fault), .fault_level(fault_level), .fault_cause(fault_cause),
    .pa(pa), .cacheable(cacheable), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model: one acknowledge per request, one cycle later
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // table layout used by the bench
  localparam logic [31:0] PTR      = 32'h0000_1000;
  localparam logic [3:0]  CTX_A    = 4'd3;
  localparam logic [7:0]  RI       = 8'hA5;
  localparam logic [5:0]  SI       = 6'h2B;
  localparam logic [5:0]  PI       = 6'h17;
  localparam logic [11:0] OFS      = 12'h9C4;
  localparam logic [31:0] VA_A     = {RI, SI, PI, OFS};
  localparam logic [31:0] CTX_SLOT = 32'h1_0000 + 4 * CTX_A;
  localparam logic [31:0] REG_SLOT = 32'h2_0000 + 4 * RI;
  localparam logic [31:0] SEG_SLOT = 32'h3_0000 + 4 * SI;
  localparam logic [31:0] PG_SLOT  = 32'h4_0000 + 4 * PI;
  localparam logic [23:0] PPN      = 24'hABCDE1;

  // vector: {code[2:0], user, write, expect_fault}
  localparam int NVEC = 12;
  localparam logic [5:0] VEC [NVEC] = '{
    {3'd0, 1'b1, 1'b0, 1'b0}, {3'd5, 1'b1, 1'b0, 1'b0},
    {3'd6, 1'b1, 1'b0, 1'b1}, {3'd7, 1'b1, 1'b0, 1'b1},
    {3'd1, 1'b1, 1'b1, 1'b0}, {3'd3, 1'b1, 1'b1, 1'b0},
    {3'd5, 1'b1, 1'b1, 1'b1}, {3'd2, 1'b1, 1'b1, 1'b1},
    {3'd5, 1'b0, 1'b1, 1'b0}, {3'd7, 1'b0, 1'b1, 1'b0},
    {3'd4, 1'b0, 1'b1, 1'b1}, {3'd6, 1'b0, 1'b0, 1'b0}
  };

  logic        r_fault, r_cache, r_timeout;
  logic [1:0]  r_lvl, r_cause;
  logic [35:0] r_pa;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_tables();
    mem.delete();
    mem[CTX_SLOT] = 32'h2001;
    mem[REG_SLOT] = 32'h3001;
    mem[SEG_SLOT] = 32'h4001;
  endtask

  function automatic logic [31:0] mk_leaf(input logic [2:0] code, input logic c,
                                          input logic m, input logic r);
    return {PPN, c, m, r, code, 2'b10};
  endfunction

  task automatic walk(input logic [31:0] v, input logic [3:0] c, input logic u, input logic w);
    int n;
    @(negedge clk);
    va = v; ctx = c; ctp = PTR; is_user = u; is_write = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    r_timeout = 1'b0;
    while (!done && n < WALK_LIMIT) begin
      @(negedge clk);
      n++;
    end
    if (!done) r_timeout = 1'b1;
    chk("R9 walk completes", r_timeout, 1'b0);
    r_fault = fault; r_cache = cacheable; r_lvl = fault_level;
    r_cause = fault_cause; r_pa = pa;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", busy, 1'b0);
    chk("R10 req in reset", mem_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 done after reset", done, 1'b0);
    chk("R10 busy after reset", busy, 1'b0);
    chk("R10 req after reset", mem_req, 1'b0);

    // table walk of permission vectors (R5 R6 R7 R8 R1 R2)
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] code;
      logic u, w, ef;
      logic [31:0] exp_leaf;
      {code, u, w, ef} = VEC[i];
      build_tables();
      mem[PG_SLOT] = mk_leaf(code, i[0], 1'b0, 1'b0);
      wr_cnt = 0;
      walk(VA_A, CTX_A, u, w);
      chk($sformatf("R5 R6 vec%0d fault", i), r_fault, ef);
      if (ef) begin
        chk($sformatf("R6 vec%0d cause", i), {r_lvl, r_cause}, {2'd3, 2'd3});
        chk($sformatf("R8 vec%0d no write on fault", i), wr_cnt, 0);
      end else begin
        exp_leaf = mk_leaf(code, i[0], w, 1'b1);
        chk($sformatf("R7 vec%0d pa", i), r_pa, {PPN, OFS});
        chk($sformatf("R7 vec%0d cacheable", i), r_cache, i[0]);
        chk($sformatf("R8 vec%0d one write", i), wr_cnt, 1);
        chk($sformatf("R8 vec%0d leaf", i), mem[PG_SLOT], exp_leaf);
      end
    end

    // R8: no write when flags already set
    build_tables();
    mem[PG_SLOT] = mk_leaf(3'd1, 1'b1, 1'b0, 1'b1);
    wr_cnt = 0;
    walk(VA_A, CTX_A, 1'b0, 1'b0);
    chk("R8 read with ref set no write", wr_cnt, 0);
    walk(VA_A, CTX_A, 1'b0, 1'b1);
    chk("R8 first write sets modified", mem[PG_SLOT], mk_leaf(3'd1, 1'b1, 1'b1, 1'b1));
    wr_cnt = 0;
    walk(VA_A, CTX_A, 1'b0, 1'b1);
    chk("R8 repeat write no write", wr_cnt, 0);
    chk("R7 repeat pa", r_pa, {PPN, OFS});

    // R3: upper level types
    build_tables();
    mem[PG_SLOT] = mk_leaf(3'd3, 1'b0, 1'b0, 1'b0);
    mem[CTX_SLOT] = 32'h2003;
    walk(VA_A, CTX_A, 1'b0, 1'b0);
    chk("R3 ctx reserved type", {r_fault, r_lvl, r_cause}, {1'b1, 2'd0, 2'd2});
    mem[CTX_SLOT] = 32'h2001;
    mem[REG_SLOT] = 32'h3000;
    walk(VA_A, CTX_A, 1'b0, 1'b0);
    chk("R3 region invalid", {r_fault, r_lvl, r_cause}, {1'b1, 2'd1, 2'd1});
    mem[REG_SLOT] = 32'h3001;
    mem[SEG_SLOT] = 32'h4002;
    wr_cnt = 0;
    walk(VA_A, CTX_A, 1'b0, 1'b0);
    chk("R3 segment leaf type", {r_fault, r_lvl, r_cause}, {1'b1, 2'd2, 2'd2});
    chk("R8 no write on type fault", wr_cnt, 0);

    // R4: page level types
    mem[SEG_SLOT] = 32'h4001;
    mem[PG_SLOT] = 32'h5001;
    walk(VA_A, CTX_A, 1'b0, 1'b0);
    chk("R4 page descriptor type", {r_fault, r_lvl, r_cause}, {1'b1, 2'd3, 2'd2});
    mem[PG_SLOT] = 32'h0;
    walk(VA_A, CTX_A, 1'b0, 1'b0);
    chk("R4 page invalid", {r_fault, r_lvl, r_cause}, {1'b1, 2'd3, 2'd1});

    // R1: other context slot
    build_tables();
    mem[PG_SLOT] = mk_leaf(3'd3, 1'b0, 1'b0, 1'b0);
    walk(VA_A, 4'd5, 1'b0, 1'b0);
    chk("R1 empty ctx slot", {r_fault, r_lvl, r_cause}, {1'b1, 2'd0, 2'd1});
    mem[32'h1_0000 + 4 * 5] = 32'h2001;
    walk(VA_A, 4'd5, 1'b0, 1'b0);
    chk("R1 ctx slot 5 ok", {r_fault, r_pa}, {1'b0, PPN, OFS});

    // R2: different indices reach different slots
    mem[32'h2_0000 + 4 * 8'h11] = 32'h3001;
    mem[32'h3_0000 + 4 * 6'h3F] = 32'h6001;
    mem[32'h6_0000 + 4 * 6'h00] = {24'h00F00D, 8'b1000_1110};
    walk({8'h11, 6'h3F, 6'h00, 12'h123}, CTX_A, 1'b0, 1'b0);
    chk("R2 alternate indices pa", {r_fault, r_pa}, {1'b0, 24'h00F00D, 12'h123});
    chk("R7 alternate cacheable", r_cache, 1'b1);

    // R9: start during a walk is ignored
    build_tables();
    mem[PG_SLOT] = mk_leaf(3'd3, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    va = VA_A; ctx = CTX_A; ctp = PTR; is_user = 1'b0; is_write = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    va = 32'hFFFF_FFFF; ctx = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n = 0;
      while (!done && n < WALK_LIMIT) begin @(negedge clk); n++; end
    end
    chk("R9 first walk result kept", {fault, pa}, {1'b0, PPN, OFS});
    @(negedge clk);
    chk("R9 done lasts one cycle", done, 1'b0);
    begin
      logic seen = 1'b0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (busy || done) seen = 1'b1;
      end
      chk("R9 ignored start not queued", seen, 1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule